// File: doc/BRIEF.md
# Subsequent-Violation Window Scanner

This block keeps a record of which requestors raised an access violation while an earlier violation was still being held elsewhere. It stores one flag per requestor ID and groups the flags into 16-bit windows. Each violation strobe carries a requestor ID and sets that requestor's flag. IDs at or above the implemented count are dropped.

Software reads the record one window at a time. A read request starts a circular search. The search begins at a software-writable window index and advances one window per cycle. It wraps from the last window to window 0 and stops at the first window that holds a set flag. The response reports that window's flags, its index and a found bit. The window it returns is then cleared, and the stored index moves to that window. When every window is empty, the response reports found = 0 and the index the search started from. A separate pending output is high while any flag is set, so software can skip reading an empty record.

Top module: `svw_scanner`

## Requirements
- R1: After reset, `rd_valid` and `pending` are 0, every flag is clear, and the stored window index is 0.
- R2: A `viol_vld` strobe with ID `w*16 + j` sets bit j of window w.
- R3: A read response has the window flags in `rd_data[15:0]`, the window index in `rd_data[27:16]` and the found bit in `rd_data[31]`. Bits 30:28 are 0.
- R4: A read searches the windows starting at the stored index and wraps from window NUM_WIN-1 to window 0. It reports the first window with any set flag, and that window's index becomes the stored index.
- R5: When no window holds a set flag, the response has found = 0, flags = 0, and the starting index. The stored index does not change.
- R6: A request sampled at edge k is answered by a one-cycle `rd_valid` pulse at edge k+1+d when the hit is d windows past the start, or at edge k+NUM_WIN when there is no hit.
- R7: The window reported with found = 1 is cleared by the same edge that raises `rd_valid`, so a later read does not report those flags again.
- R8: A violation that lands in the window being cleared, at the clearing edge, stays recorded. The response still shows the window's contents from before that edge.
- R9: `pending` is 1 after any edge that leaves a flag set, and 0 after an edge that leaves every flag clear.
- R10: A write while idle stores `wr_data[27:16]` modulo NUM_WIN as the window index. Writes and read requests made while a search is running are ignored.
- R11: A strobe whose ID is NUM_IDS or higher changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol_vld | input | 1 | Subsequent-violation strobe |
| viol_id | input | ID_W | Requestor ID of the violation |
| rd_req | input | 1 | Read request, starts a search |
| wr_en | input | 1 | Index write enable |
| wr_data | input | 32 | Write data; bits 27:16 give the index |
| rd_valid | output | 1 | One-cycle read response strobe |
| rd_data | output | 32 | Found bit, index and window flags |
| pending | output | 1 | Any flag recorded |

## Verification
Flags and `pending` are updated by the edge that samples a strobe. The bench therefore checks `pending` at the falling edge that follows. For a read, the bench computes the hit distance d from its own flag model before it issues the request. It counts rising edges from the request edge until `rd_valid` appears and compares that count with d+1, or with NUM_WIN on a miss. It samples `rd_data` at that same falling edge and confirms one cycle later that the pulse has dropped. Strobes and writes that must coincide with the scan are driven in the half cycle before edge k+1, so they land on the first search step.

// File: rtl/svw_pkg.sv
package svw_pkg;
  localparam int WIN_BITS    = 16;
  localparam int IDX_FIELD_W = 12;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;

  function automatic logic [31:0] pack_status(input logic found,
                                              input logic [IDX_FIELD_W-1:0] idx,
                                              input logic [WIN_BITS-1:0] bits);
    return {found, 3'b000, idx, bits};
  endfunction
endpackage

// File: rtl/svw_flag_store.sv
module svw_flag_store #(
  parameter int NUM_IDS   = 40,
  parameter int ID_W      = 8,
  parameter int WIN_BITS  = 16,
  parameter int NUM_WIN   = 3,
  parameter int WIN_IDX_W = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               set_vld,
  input  logic [ID_W-1:0]                    set_id,
  input  logic                               clr_en,
  input  logic [WIN_IDX_W-1:0]               clr_win,
  output logic [NUM_WIN-1:0][WIN_BITS-1:0]   win_bits,
  output logic                               pending
);
  localparam int WIN_SH = $clog2(WIN_BITS);

  logic                              id_ok;
  logic [ID_W-1:0]                   set_win;
  logic [WIN_SH-1:0]                 set_bit;
  logic [NUM_WIN-1:0][WIN_BITS-1:0]  flags_q;
  logic [NUM_WIN-1:0][WIN_BITS-1:0]  flags_d;
  logic                              any_d;
  logic                              pending_q;

  assign id_ok   = set_vld && (int'(set_id) < NUM_IDS);
  assign set_win = set_id >> WIN_SH;
  assign set_bit = set_id[WIN_SH-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [WIN_BITS-1:0] set_mask;
    logic [WIN_BITS-1:0] kept;
    always_comb begin
      set_mask = '0;
      if (id_ok && (set_win == ID_W'(w))) set_mask[set_bit] = 1'b1;
      kept = (clr_en && (clr_win == WIN_IDX_W'(w))) ? '0 : flags_q[w];
      flags_d[w] = kept | set_mask;
    end

    always_ff @(posedge clk) begin
      if (rst) flags_q[w] <= '0;
      else     flags_q[w] <= flags_d[w];
    end
  end

  always_comb begin
    any_d = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) any_d = any_d | (|flags_d[w]);
  end

  always_ff @(posedge clk) begin
    if (rst) pending_q <= 1'b0;
    else     pending_q <= any_d;
  end

  assign win_bits = flags_q;
  assign pending  = pending_q;

  // R9: an accepted strobe leaves pending high
  a_r9_pending_after_set: assert property (@(posedge clk) disable iff (rst)
    id_ok |=> pending);

  // R7: a cleared window with no concurrent strobe reads as empty
  a_r7_window_cleared: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_vld) |=> (win_bits[$past(clr_win)] == '0));

  // R8: a strobe into the window being cleared survives
  a_r8_concurrent_kept: assert property (@(posedge clk) disable iff (rst)
    (clr_en && id_ok && (set_win == ID_W'(clr_win)))
      |=> (win_bits[$past(clr_win)] == (WIN_BITS'(1) << $past(set_bit))));

  // R11: out-of-range IDs leave the flags untouched
  a_r11_ignore_range: assert property (@(posedge clk) disable iff (rst)
    (set_vld && !id_ok && !clr_en) |=> $stable(win_bits));
endmodule

// File: rtl/svw_scan_ctrl.sv
module svw_scan_ctrl
  import svw_pkg::*;
#(
  parameter int NUM_WIN   = 3,
  parameter int WIN_IDX_W = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_req,
  input  logic                              wr_en,
  input  logic [IDX_FIELD_W-1:0]            wr_idx,
  input  logic [NUM_WIN-1:0][WIN_BITS-1:0]  win_bits,
  output logic                              clr_en,
  output logic [WIN_IDX_W-1:0]              clr_win,
  output logic                              rd_valid,
  output logic [31:0]                       rd_data
);
  localparam logic [WIN_IDX_W-1:0] LAST_WIN = WIN_IDX_W'(NUM_WIN - 1);

  scan_state_t          state_q;
  logic [WIN_IDX_W-1:0] svi_q;
  logic [WIN_IDX_W-1:0] cur_q;
  logic [WIN_IDX_W-1:0] cnt_q;
  logic [WIN_IDX_W-1:0] cur_next;
  logic [WIN_IDX_W-1:0] wr_wrapped;
  logic [WIN_IDX_W-1:0] start_idx;
  logic [WIN_BITS-1:0]  cur_bits;
  logic                 hit;
  logic                 scan_done;
  logic                 rd_valid_q;
  logic [31:0]          rd_data_q;

  function automatic logic [WIN_IDX_W-1:0] wrap_idx(input logic [IDX_FIELD_W-1:0] v);
    logic [IDX_FIELD_W-1:0] m;
    m = v % IDX_FIELD_W'(NUM_WIN);
    return WIN_IDX_W'(m);
  endfunction

  assign wr_wrapped = wrap_idx(wr_idx);
  assign start_idx  = wr_en ? wr_wrapped : svi_q;
  assign cur_bits   = win_bits[cur_q];
  assign hit        = (state_q == ST_SCAN) && (|cur_bits);
  assign scan_done  = (cnt_q == LAST_WIN);
  assign cur_next   = (cur_q == LAST_WIN) ? '0 : cur_q + 1'b1;

  assign clr_en  = hit;
  assign clr_win = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      svi_q      <= '0;
      cur_q      <= '0;
      cnt_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (wr_en) svi_q <= wr_wrapped;
          if (rd_req) begin
            state_q <= ST_SCAN;
            cur_q   <= start_idx;
            cnt_q   <= '0;
          end
        end
        ST_SCAN: begin
          if (hit) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= pack_status(1'b1, IDX_FIELD_W'(cur_q), cur_bits);
            svi_q      <= cur_q;
            state_q    <= ST_IDLE;
          end else if (scan_done) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= pack_status(1'b0, IDX_FIELD_W'(svi_q), '0);
            state_q    <= ST_IDLE;
          end else begin
            cur_q <= cur_next;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R6: the response strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R3: reserved bits are zero and the index is in range
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[30:28] == 3'b000) && (int'(rd_data[27:16]) < NUM_WIN));

  // R5: a miss carries no flags
  a_r5_miss_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_data[31]) |-> (rd_data[15:0] == '0));

  // R4: a found window is never empty
  a_r4_found_nonempty: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_data[31]) |-> (rd_data[15:0] != '0));

  // R10: the stored index stays in range and holds during a search
  a_r10_index_range: assert property (@(posedge clk) disable iff (rst)
    int'(svi_q) < NUM_WIN);
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SCAN) && !hit) |=> $stable(svi_q));
endmodule

// File: rtl/svw_scanner.sv
module svw_scanner
  import svw_pkg::*;
#(
  parameter int NUM_IDS = 40,
  parameter int ID_W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            viol_vld,
  input  logic [ID_W-1:0] viol_id,
  input  logic            rd_req,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic            rd_valid,
  output logic [31:0]     rd_data,
  output logic            pending
);
  localparam int NUM_WIN   = (NUM_IDS + WIN_BITS - 1) / WIN_BITS;
  localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [NUM_WIN-1:0][WIN_BITS-1:0] win_bits;
  logic                             clr_en;
  logic [WIN_IDX_W-1:0]             clr_win;

  svw_flag_store #(
    .NUM_IDS  (NUM_IDS),
    .ID_W     (ID_W),
    .WIN_BITS (WIN_BITS),
    .NUM_WIN  (NUM_WIN),
    .WIN_IDX_W(WIN_IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .set_vld (viol_vld),
    .set_id  (viol_id),
    .clr_en  (clr_en),
    .clr_win (clr_win),
    .win_bits(win_bits),
    .pending (pending)
  );

  svw_scan_ctrl #(
    .NUM_WIN  (NUM_WIN),
    .WIN_IDX_W(WIN_IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .wr_en   (wr_en),
    .wr_idx  (wr_data[27:16]),
    .win_bits(win_bits),
    .clr_en  (clr_en),
    .clr_win (clr_win),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );
endmodule

// File: tb/test_svw_scanner.sv
`timescale 1ns/1ps
module test_svw_scanner;
  localparam int NUM_IDS = 40;
  localparam int ID_W    = 8;
  localparam int NWIN    = (NUM_IDS + 15) / 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            viol_vld = 1'b0;
  logic [ID_W-1:0] viol_id = '0;
  logic            rd_req = 1'b0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic            pending;

  int total = 0;
  int bad = 0;
  logic [NWIN*16-1:0] exp_flags = '0;
  int exp_idx = 0;

  always #5 clk = ~clk;

  svw_scanner #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) i_svw_scanner (
    .clk(clk), .rst(rst), .viol_vld(viol_vld), .viol_id(viol_id),
    .rd_req(rd_req), .wr_en(wr_en), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .pending(pending)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input int id);
    @(negedge clk);
    viol_vld = 1'b1;
    viol_id  = ID_W'(id);
    @(posedge clk);
    @(negedge clk);
    viol_vld = 1'b0;
    if (id < NUM_IDS) exp_flags[id] = 1'b1;
    check(pending == (|exp_flags), "R9/R2 pending after strobe", 32'(pending), 32'(|exp_flags));
  endtask

  task automatic write_idx(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    exp_idx = int'(d[27:16]) % NWIN;
  endtask

  task automatic do_read(input bit conc, input int cid, input bit busy_wr, input string tag);
    bit found = 1'b0;
    int d = 0;
    int hw = 0;
    int n = 0;
    int exp_n;
    logic [31:0] exp_data;
    for (int i = 0; i < NWIN; i++) begin
      int w = (exp_idx + i) % NWIN;
      if (!found && (exp_flags[w*16 +: 16] != '0)) begin
        found = 1'b1; d = i; hw = w;
      end
    end
    if (found) begin
      exp_data = {1'b1, 3'b000, 12'(hw), exp_flags[hw*16 +: 16]};
      exp_n = d + 1;
    end else begin
      exp_data = {1'b0, 3'b000, 12'(exp_idx), 16'h0};
      exp_n = NWIN;
    end
    @(negedge clk);
    rd_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    if (conc) begin viol_vld = 1'b1; viol_id = ID_W'(cid); end
    if (busy_wr) begin wr_en = 1'b1; wr_data = 32'h0001_0000; rd_req = 1'b1; end
    while (n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      viol_vld = 1'b0; wr_en = 1'b0; rd_req = 1'b0;
      if (rd_valid) break;
    end
    check(n == exp_n, {"R6 latency ", tag}, 32'(n), 32'(exp_n));
    check(rd_data == exp_data, {"R3/R4/R5 data ", tag}, rd_data, exp_data);
    if (found) begin
      exp_idx = hw;
      exp_flags[hw*16 +: 16] = '0;
    end
    if (conc && cid < NUM_IDS) exp_flags[cid] = 1'b1;
    @(negedge clk);
    check(!rd_valid, {"R6 pulse ", tag}, 32'(rd_valid), 32'h0);
    check(pending == (|exp_flags), {"R7/R9 pending after read ", tag}, 32'(pending), 32'(|exp_flags));
  endtask

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!rd_valid, "R1 rd_valid", 32'(rd_valid), 32'h0);
    check(!pending, "R1 pending", 32'(pending), 32'h0);
    do_read(0, 0, 0, "R1 empty after reset");
    // R2, R3, R7 single flag
    strobe(5);
    do_read(0, 0, 0, "R2 id5");
    do_read(0, 0, 0, "R7 cleared");
    // R4 wrap
    strobe(33);
    strobe(20);
    write_idx(32'h0002_0000);
    do_read(0, 0, 0, "R4 start2");
    do_read(0, 0, 0, "R4 wrap to 1");
    // R10 modulo write: 7 mod 3 = 1
    write_idx(32'h0007_0000);
    do_read(0, 0, 0, "R10 modulo");
    // R11 out-of-range IDs
    strobe(45);
    strobe(200);
    do_read(0, 0, 0, "R11 ignored");
    // R8 concurrent strobe into cleared window
    strobe(17);
    do_read(1, 18, 0, "R8 first");
    do_read(0, 0, 0, "R8 kept");
    // R10 busy write and request ignored
    do_read(0, 0, 1, "R10 busy");
    do_read(0, 0, 0, "R10 after busy");
    // random mix
    for (int it = 0; it < 300; it++) begin
      int r = $urandom % 10;
      if (r < 5) strobe($urandom % 48);
      else if (r < 8) do_read(0, 0, 0, "random");
      else write_idx($urandom);
    end
    do_read(0, 0, 0, "final");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule